// File: doc/BRIEF.md
# DRAM CBR Refresh Scheduler

This block keeps a 32-bit fast-page-mode DRAM module alive. It issues CAS-before-RAS refresh cycles, so the DRAM's own row counter picks the row to refresh and the address bus is never driven. An interval timer, counted in system clock cycles, adds one owed refresh to a small queue every period. The default period is 16 ms divided by 1024 rows, rounded down to whole cycles. While refreshes are owed, the block raises a request toward the memory access sequencer. When the sequencer grants the bus, the block plays out one complete refresh cycle on the strobes.

Each refresh cycle runs in four phases. CAS goes low first. RAS follows while CAS is still held low. CAS is then released while RAS stays low for the minimum low time. Last comes a RAS precharge, and the request stays asserted until the precharge has ended. All RAS lanes switch together, covering both sides of the module, and so do all CAS lanes. Write enable stays high throughout. If the sequencer holds the grant, owed refreshes are paid back one after another. If the queue gets too deep, a sticky overrun flag records that the refresh budget is at risk.

Every edge delay is a parameter in nanoseconds. The block turns each one into whole clock cycles by rounding up, with a minimum of one cycle.

Top module: `dramRefreshSched`

## Requirements
- R1: While reset is asserted, and right after it, every RAS and CAS lane is high, write enable is high, the request is low, the owed count is 0 and the overrun flag is 0.
- R2: The owed count rises by one every INT_CYC = INTERVAL_NS/CLK_NS cycles. After reset is released, the first request appears at the end of cycle INT_CYC.
- R3: The request is high whenever the block is idle with a nonzero owed count, and it stays high until the precharge of the refresh cycle has ended. The grant is sampled only in the idle state. A grant with nothing owed does nothing. A grant held for a single cycle still produces one complete refresh cycle.
- R4: CAS goes low exactly CSR_CYC = ceil(CSR_NS/CLK_NS) cycles before RAS goes low.
- R5: CAS stays low for CHR_CYC = ceil(CHR_NS/CLK_NS) cycles counted from the RAS fall, then rises while RAS is still low.
- R6: RAS stays low for exactly max(ceil(RAS_NS/CLK_NS), CHR_CYC+1) cycles.
- R7: After RAS rises, RAS and CAS both stay high for PRECH_CYC = max(ceil(RP_NS/CLK_NS), ceil(RPC_NS/CLK_NS)) cycles while the request is held. Only then can a new cycle start.
- R8: Write enable is high at all times. All LANES RAS outputs carry the same value, and so do all LANES CAS outputs.
- R9: Starting a refresh cycle lowers the owed count by one. The count saturates at PEND_MAX, which defaults to 8. While the grant is held, owed refreshes run back to back until the count is 0.
- R10: The overrun flag is set when the owed count reaches OVR_DEPTH, which defaults to 3. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Bus granted to refresh by the access sequencer |
| refReq | output | 1 | Refresh wants or holds the bus |
| rasN | output | LANES (4) | Row strobes, active low, all lanes equal |
| casN | output | LANES (4) | Column strobes, active low, all lanes equal |
| weN | output | 1 | Write enable, active low, held high |
| pendCount | output | $clog2(PEND_MAX+1) (4) | Number of refreshes owed |
| overrun | output | 1 | Sticky flag: owed count reached OVR_DEPTH |

## Verification
The bench builds the block with a 10 ns clock and INTERVAL_NS set to 400, so a request falls due every 40 cycles. With that setting, multi-interval waits, queue saturation at 8 and the overrun threshold can all be reached within a few hundred cycles. The edge parameters keep their defaults. They give a 1-cycle CAS lead, a 1-cycle CAS hold, a 5-cycle RAS low and a 3-cycle precharge, so every phase length is checked exactly against those counts.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HOLD,
    ST_RASONLY,
    ST_PRECH
  } refState_t;

  typedef struct packed {
    logic consume;
    logic phClr;
    logic rasAct;
    logic casAct;
  } strobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refCtrl.sv
module refCtrl
  import refsch_pkg::*;
#(
  parameter int LEAD_CYC  = 1,
  parameter int HOLD_CYC  = 1,
  parameter int REST_CYC  = 4,
  parameter int PRECH_CYC = 3,
  parameter int PH_W      = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pendNz,
  input  logic            refGrant,
  input  logic [PH_W-1:0] phaseCnt,
  output strobe_t         strb,
  output logic            refReq
);

  refState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (pendNz && refGrant)                 nextState = ST_LEAD;
      ST_LEAD:    if (phaseCnt == PH_W'(LEAD_CYC - 1))    nextState = ST_HOLD;
      ST_HOLD:    if (phaseCnt == PH_W'(HOLD_CYC - 1))    nextState = ST_RASONLY;
      ST_RASONLY: if (phaseCnt == PH_W'(REST_CYC - 1))    nextState = ST_PRECH;
      ST_PRECH:   if (phaseCnt == PH_W'(PRECH_CYC - 1))   nextState = ST_IDLE;
      default:                                            nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb.consume = (state == ST_IDLE) && (nextState == ST_LEAD);
    strb.phClr   = (nextState != state) || (state == ST_IDLE);
    strb.casAct  = (nextState == ST_LEAD) || (nextState == ST_HOLD);
    strb.rasAct  = (nextState == ST_HOLD) || (nextState == ST_RASONLY);
  end

  assign refReq = (state == ST_IDLE) ? pendNz : 1'b1;

endmodule

// File: rtl/refDatapath.sv
module refDatapath
  import refsch_pkg::*;
#(
  parameter int INT_CYC   = 1562,
  parameter int PEND_MAX  = 8,
  parameter int OVR_DEPTH = 3,
  parameter int PH_W      = 3,
  parameter int LANES     = 4,
  parameter int PEND_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic              pendNz,
  output logic [PH_W-1:0]   phaseCnt,
  output logic [LANES-1:0]  rasN,
  output logic [LANES-1:0]  casN,
  output logic              weN,
  output logic [PEND_W-1:0] pendCount,
  output logic              overrun
);

  localparam int TMR_W = (INT_CYC > 2) ? $clog2(INT_CYC) : 1;

  logic [TMR_W-1:0]  tmrCnt;
  logic              tick;
  logic              pendInc;
  logic [PEND_W-1:0] pendQ, pendNext;
  logic              ovrQ;

  // interval timer
  assign tick = (tmrCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     tmrCnt <= TMR_W'(INT_CYC - 1);
    else if (tick) tmrCnt <= TMR_W'(INT_CYC - 1);
    else           tmrCnt <= tmrCnt - TMR_W'(1);
  end

  // owed refresh queue (a saturating count)
  assign pendInc = tick && ((pendQ != PEND_W'(PEND_MAX)) || strb.consume);

  always_comb begin
    pendNext = pendQ;
    if (pendInc)      pendNext = pendNext + PEND_W'(1);
    if (strb.consume) pendNext = pendNext - PEND_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          ovrQ <= 1'b0;
    else if (tick && (pendNext >= PEND_W'(OVR_DEPTH)))  ovrQ <= 1'b1;
  end

  // phase length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseCnt <= '0;
    else if (strb.phClr) phaseCnt <= '0;
    else                 phaseCnt <= phaseCnt + PH_W'(1);
  end

  // registered strobe lanes, one flop pair per lane
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rasN[lane] <= 1'b1;
        casN[lane] <= 1'b1;
      end else begin
        rasN[lane] <= ~strb.rasAct;
        casN[lane] <= ~strb.casAct;
      end
    end
  end

  assign weN       = 1'b1;
  assign pendNz    = (pendQ != '0);
  assign pendCount = pendQ;
  assign overrun   = ovrQ;

endmodule

// File: rtl/dramRefreshSched.sv
module dramRefreshSched
  import refsch_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int INTERVAL_NS = 15625,
  parameter int CSR_NS      = 5,
  parameter int CHR_NS      = 10,
  parameter int RAS_NS      = 50,
  parameter int RP_NS       = 30,
  parameter int RPC_NS      = 5,
  parameter int PEND_MAX    = 8,
  parameter int OVR_DEPTH   = 3,
  parameter int LANES       = 4,
  localparam int PEND_W     = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGrant,
  output logic              refReq,
  output logic [LANES-1:0]  rasN,
  output logic [LANES-1:0]  casN,
  output logic              weN,
  output logic [PEND_W-1:0] pendCount,
  output logic              overrun
);

  localparam int INT_CYC   = INTERVAL_NS / CLK_NS;
  localparam int LEAD_CYC  = nsToCyc(CSR_NS, CLK_NS);
  localparam int HOLD_CYC  = nsToCyc(CHR_NS, CLK_NS);
  localparam int RASL_CYC  = maxOf(nsToCyc(RAS_NS, CLK_NS), HOLD_CYC + 1);
  localparam int REST_CYC  = RASL_CYC - HOLD_CYC;
  localparam int PRECH_CYC = maxOf(nsToCyc(RP_NS, CLK_NS), nsToCyc(RPC_NS, CLK_NS));
  localparam int MAX_PH    = maxOf(maxOf(LEAD_CYC, HOLD_CYC), maxOf(REST_CYC, PRECH_CYC));
  localparam int PH_W      = $clog2(MAX_PH + 1);

  strobe_t         strb;
  logic            pendNz;
  logic [PH_W-1:0] phaseCnt;

  refCtrl #(
    .LEAD_CYC (LEAD_CYC),
    .HOLD_CYC (HOLD_CYC),
    .REST_CYC (REST_CYC),
    .PRECH_CYC(PRECH_CYC),
    .PH_W     (PH_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pendNz  (pendNz),
    .refGrant(refGrant),
    .phaseCnt(phaseCnt),
    .strb    (strb),
    .refReq  (refReq)
  );

  refDatapath #(
    .INT_CYC  (INT_CYC),
    .PEND_MAX (PEND_MAX),
    .OVR_DEPTH(OVR_DEPTH),
    .PH_W     (PH_W),
    .LANES    (LANES),
    .PEND_W   (PEND_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pendNz   (pendNz),
    .phaseCnt (phaseCnt),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .pendCount(pendCount),
    .overrun  (overrun)
  );

endmodule

// File: rtl/refSchedChk.sv
module refSchedChk #(
  parameter int RASL_CYC  = 5,
  parameter int PRECH_CYC = 3,
  parameter int PEND_MAX  = 8,
  parameter int LANES     = 4,
  parameter int PEND_W    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              refGrant,
  input logic              refReq,
  input logic [LANES-1:0]  rasN,
  input logic [LANES-1:0]  casN,
  input logic [PEND_W-1:0] pendCount,
  input logic              overrun
);

  logic [7:0] lowRun, highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
    end else begin
      lowRun  <= rasN[0] ? 8'd0 : ((lowRun == 8'hFF) ? lowRun : lowRun + 8'd1);
      highRun <= !rasN[0] ? 8'd0 : ((highRun == 8'hFF) ? highRun : highRun + 8'd1);
    end
  end

  // R3
  start_on_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN[0]) && rasN[0]) |-> ($past(refGrant) && $past(refReq)));

  // R3
  req_during_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN[0] || !casN[0]) |-> refReq);

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> $past(!casN[0]));

  // R5
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> !casN[0]);

  // R5
  cas_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN[0]) |-> !rasN[0]);

  // R6
  ras_low_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN[0]) |-> (lowRun == 8'(RASL_CYC)));

  // R7
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> (highRun >= 8'(PRECH_CYC)));

  // R8
  lanes_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasN == {LANES{rasN[0]}}) && (casN == {LANES{casN[0]}}));

  // R9
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_W'(PEND_MAX));

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind dramRefreshSched refSchedChk #(
  .RASL_CYC (RASL_CYC),
  .PRECH_CYC(PRECH_CYC),
  .PEND_MAX (PEND_MAX),
  .LANES    (LANES),
  .PEND_W   (PEND_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refGrant (refGrant),
  .refReq   (refReq),
  .rasN     (rasN),
  .casN     (casN),
  .pendCount(pendCount),
  .overrun  (overrun)
);

// File: tb/sim_dramRefreshSched.sv
module sim_dramRefreshSched;

  localparam int CLK_NS = 10;
  localparam int INT_NS = 400;
  localparam int INT    = INT_NS / CLK_NS;   // 40
  localparam int E_LEAD = 1;                 // ceil(5/10)
  localparam int E_HOLD = 1;                 // ceil(10/10)
  localparam int E_RASL = 5;                 // ceil(50/10)
  localparam int E_PRE  = 3;                 // max(ceil(30/10), ceil(5/10))

  typedef struct packed {
    logic [3:0] n;
    logic       ovr;
    logic       pulse;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{n: 4'd1, ovr: 1'b0, pulse: 1'b0},
    '{n: 4'd2, ovr: 1'b0, pulse: 1'b0},
    '{n: 4'd1, ovr: 1'b0, pulse: 1'b1},
    '{n: 4'd3, ovr: 1'b1, pulse: 1'b0},
    '{n: 4'd2, ovr: 1'b1, pulse: 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       refGrant;
  logic       refReq;
  logic [3:0] rasN, casN;
  logic       weN;
  logic [3:0] pendCount;
  logic       overrun;

  int nChecks = 0;
  int nErr    = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  dramRefreshSched #(
    .CLK_NS     (CLK_NS),
    .INTERVAL_NS(INT_NS)
  ) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .refReq   (refReq),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .pendCount(pendCount),
    .overrun  (overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  // Grant the bus and follow the strobes until the request drops.
  task automatic drain(input bit pulse, input bit chkCount, input int expFalls);
    int  falls   = 0;
    int  lead    = 0;
    int  hold    = 0;
    int  low     = 0;
    int  highRun = 0;
    bit  prevRas = 1'b1;
    bit  laneBad = 1'b0;
    bit  ras, cas;
    int  steps   = 0;
    refGrant = 1'b1;
    forever begin
      @(negedge clk);
      steps++;
      if (pulse && steps == 1) refGrant = 1'b0;
      if (!refReq) break;
      ras = rasN[0];
      cas = casN[0];
      if (rasN != {4{ras}} || casN != {4{cas}} || weN !== 1'b1) laneBad = 1'b1;
      if (!cas && ras) lead++;
      if (prevRas && !ras) begin
        falls++;
        chk(lead == E_LEAD, "R4 cas lead", lead, E_LEAD);
        if (falls > 1) chk(highRun >= E_PRE, "R7 ras high gap", highRun, E_PRE);
        lead = 0; hold = 0; low = 0;
      end
      if (!ras) begin
        low++;
        if (!cas) hold++;
      end
      if (!prevRas && ras) begin
        chk(low == E_RASL, "R6 ras low length", low, E_RASL);
        chk(hold == E_HOLD, "R5 cas hold after ras", hold, E_HOLD);
        highRun = 0;
      end
      if (ras) highRun++;
      prevRas = ras;
    end
    refGrant = 1'b0;
    chk(highRun == E_PRE, "R7 request held through precharge", highRun, E_PRE);
    chk(!laneBad, "R8 lanes equal and write enable high", laneBad, 0);
    chk(pendCount == 0, "R9 queue empty after drain", pendCount, 0);
    if (chkCount) chk(falls == expFalls, "R9 refreshes performed", falls, expFalls);
  endtask

  initial begin
    int  n;
    bit  idleBad;
    rstN     = 1'b0;
    refGrant = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rasN == 4'hF && casN == 4'hF, "R1 strobes high in reset", {rasN, casN}, 8'hFF);
    chk(weN == 1'b1 && refReq == 1'b0, "R1 we high, no request", {weN, refReq}, 2);
    chk(pendCount == 0 && overrun == 1'b0, "R1 queue and flag clear", {pendCount, overrun}, 0);

    // R2 first request timing, R3 grant with nothing owed ignored
    rstN     = 1'b1;
    refGrant = 1'b1;
    n        = 0;
    idleBad  = 1'b0;
    while (!refReq) begin
      @(negedge clk);
      n++;
      if (n == 30) refGrant = 1'b0;
      if (n <= 30 && (rasN != 4'hF || casN != 4'hF)) idleBad = 1'b1;
      if (n > 100) break;
    end
    chk(n == INT, "R2 first request cycle", n, INT);
    chk(!idleBad, "R3 grant with nothing owed ignored", idleBad, 0);

    // vector table: wait n intervals, check queue and flag, then grant
    foreach (VEC[i]) begin
      while (!refReq) @(negedge clk);
      repeat ((int'(VEC[i].n) - 1) * INT) @(negedge clk);
      chk(pendCount == VEC[i].n, "R2 owed count after waiting", pendCount, VEC[i].n);
      chk(overrun == VEC[i].ovr, "R10 overrun flag", overrun, VEC[i].ovr);
      chk(rasN == 4'hF && casN == 4'hF, "R3 no cycle without grant", {rasN, casN}, 8'hFF);
      drain(VEC[i].pulse, 1'b1, int'(VEC[i].n));
    end

    // R9 saturation of the owed queue
    while (!refReq) @(negedge clk);
    repeat (10 * INT) @(negedge clk);
    chk(pendCount == 8, "R9 queue saturates", pendCount, 8);
    chk(refReq == 1'b1, "R3 request held while owed", refReq, 1);
    drain(1'b0, 1'b0, 0);
    chk(overrun == 1'b1, "R10 overrun stays set", overrun, 1);

    // R1 reset in the middle of a cycle
    while (!refReq) @(negedge clk);
    refGrant = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(rasN == 4'hF && casN == 4'hF, "R1 reset mid cycle strobes", {rasN, casN}, 8'hFF);
    chk(pendCount == 0 && overrun == 1'b0 && refReq == 1'b0, "R1 reset mid cycle state",
        {pendCount, overrun, refReq}, 0);
    refGrant = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(refReq == 1'b0 && rasN == 4'hF, "R1 quiet after reset", {refReq, rasN}, 4'hF);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule